// File: doc/BRIEF.md
# Falling-Edge Interrupt Cause Unit

This block watches a bank of asynchronous input pins, typically active-low interrupt lines from external devices such as an Ethernet PHY. Each pin is brought into the clock domain through a synchronizer. A high-to-low transition on a pin whose edge detection is armed latches a cause bit for that pin. The latched causes are gated by a per-pin event mask. The gated vector can be read back, and its OR drives a single registered interrupt line.

A latched cause stays set until software clears it. The clear is done by writing a one to that pin's bit in a dedicated clear register. While a cause is still set, further edges on that pin produce no new interrupt. Software therefore clears the cause at the end of its handler.

The registers sit behind a simple 32-bit bus with separate read and write strobes. Read data is registered and valid one cycle after the read strobe.

Top module: `gpio_fall_cause`

## Requirements
- R1: After synchronous reset, the edge-arm, event-mask and masked-cause registers all read 0, and the interrupt output is 0.
- R2: The edge-arm register at offset 0x48 is read/write. Bit n arms falling-edge detection for pin n.
- R3: The event-mask register at offset 0x94 is read/write. Bit n lets pin n's cause reach the read-back at offset 0x80 and the interrupt output.
- R4: A high-to-low transition on an armed pin latches that pin's cause. Offset 0x80 reads the latched causes ANDed with the event mask.
- R5: A falling edge on a pin whose arm bit is 0 latches no cause. Enabling the event mask afterwards still reads 0 for that pin.
- R6: A low-to-high transition never sets a cause and never clears one.
- R7: The interrupt output is the OR of the masked-cause vector. It rises exactly 3 clock edges after the edge that first samples a pin low: two synchronizer stages, the cause latch, and the output register.
- R8: A latched cause holds through further edges on its pin and through clears of other bits. Writing 1 to bit n of the clear register at offset 0x98 clears cause n only. The clear register reads 0.
- R9: When a clear write and a new falling edge for the same pin act in the same cycle, the clear wins and the cause ends up 0.
- R10: Reads of offsets other than 0x48, 0x80 and 0x94 return 0. Writes to offset 0x80 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 32 | Asynchronous monitored pins, idle high |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Aggregated interrupt, active high |

## Verification
A pin drop driven before clock edge k appears in the cause register after edge k+2 and on the interrupt output after edge k+3. The bench probes the interrupt one half-cycle after edge k+2, where it must still be low, and again after edge k+3, where it must be high. Read data is sampled at the falling clock edge that follows the read strobe's rising edge. Table-driven cases wait six cycles after driving the pins, which is past every latency, before reading back. The clear-versus-edge race is staged by issuing the clear write so that it lands on edge k+2, the same edge on which the new cause would otherwise be latched.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_MASKED  = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_EVT_EN  = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_CLEAR   = 8'h98;
endpackage

// File: rtl/gfc_edge.sv
module gfc_edge #(
  parameter int NPIN   = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_n,
  output logic [NPIN-1:0] fall
);
  localparam int LAST = STAGES - 1;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '1;
        prev_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], pin_n[p]};
        prev_q <= sync_q[LAST];
      end
    end

    assign fall[p] = prev_q & ~sync_q[LAST];
  end
endmodule

// File: rtl/gfc_regs.sv
module gfc_regs
  import gfc_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic [NPIN-1:0]   masked,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NPIN-1:0]   fall_en,
  output logic [NPIN-1:0]   evt_en,
  output logic [NPIN-1:0]   clr_mask
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_en <= '0;
      evt_en  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_FALL_EN) fall_en <= bus_wdata[NPIN-1:0];
      if (bus_addr == OFS_EVT_EN)  evt_en  <= bus_wdata[NPIN-1:0];
    end
  end

  always_comb begin
    clr_mask = '0;
    if (bus_wr && bus_addr == OFS_CLEAR) clr_mask = bus_wdata[NPIN-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_FALL_EN: rd_mux[NPIN-1:0] = fall_en;
      OFS_EVT_EN:  rd_mux[NPIN-1:0] = evt_en;
      OFS_MASKED:  rd_mux[NPIN-1:0] = masked;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gfc_cause.sv
module gfc_cause #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] fall,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] evt_en,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] cause_q,
  output logic [NPIN-1:0] masked,
  output logic            irq_q
);
  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= (cause_q | (fall & fall_en)) & ~clr_mask;
  end

  assign masked = cause_q & evt_en;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end
endmodule

// File: rtl/gpio_fall_cause.sv
module gpio_fall_cause #(
  parameter int NPIN        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] pin_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  logic [NPIN-1:0] fall;
  logic [NPIN-1:0] fall_en;
  logic [NPIN-1:0] evt_en;
  logic [NPIN-1:0] clr_mask;
  logic [NPIN-1:0] cause_q;
  logic [NPIN-1:0] masked;

  gfc_edge #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .pin_n (pin_n[NPIN-1:0]),
    .fall  (fall)
  );

  gfc_regs #(.NPIN(NPIN)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .masked    (masked),
    .bus_rdata (bus_rdata),
    .fall_en   (fall_en),
    .evt_en    (evt_en),
    .clr_mask  (clr_mask)
  );

  gfc_cause #(.NPIN(NPIN)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .fall     (fall),
    .fall_en  (fall_en),
    .evt_en   (evt_en),
    .clr_mask (clr_mask),
    .cause_q  (cause_q),
    .masked   (masked),
    .irq_q    (irq)
  );
endmodule

// File: rtl/gpio_fall_cause_chk.sv
module gpio_fall_cause_chk
  import gfc_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [NPIN-1:0]   cause,
  input logic [NPIN-1:0]   fall_en,
  input logic [NPIN-1:0]   evt_en
);
  // R8
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == OFS_CLEAR) |=> ((cause & $past(cause)) == $past(cause)));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CLEAR) |=> ((cause & $past(bus_wdata[NPIN-1:0])) == '0));

  // R5
  arm_needed_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(fall_en)) == '0));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(cause & evt_en)) |=> irq);

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(cause & evt_en)) |=> !irq);

  // R8
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_CLEAR) |=> (bus_rdata == '0));
endmodule

bind gpio_fall_cause gpio_fall_cause_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cause     (cause_q),
  .fall_en   (fall_en),
  .evt_en    (evt_en)
);

// File: tb/tb_gpio_fall_cause.sv
`timescale 1ns/1ps
module tb_gpio_fall_cause;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_n = '1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gpio_fall_cause dut (
    .clk(clk), .rst(rst), .pin_n(pin_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // {arm, mask, pins driven low}
  localparam logic [95:0] VEC [8] = '{
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_1000},
    {32'h0000_0001, 32'h0000_0001, 32'h0000_0001},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFFF_FFFF},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FFFF},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h8000_0001, 32'h8000_0001},
    {32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h5555_5555},
    {32'h1234_5678, 32'h0F0F_0F0F, 32'hFFFF_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait_cyc(50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp;
    wait_cyc(3);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h48, d); check("R1 arm", d, 32'h0);
    rd(8'h94, d); check("R1 mask", d, 32'h0);
    rd(8'h80, d); check("R1 masked", d, 32'h0);

    // R2 / R3 readback
    wr(8'h48, 32'hDEAD_BEEF); rd(8'h48, d); check("R2 arm readback", d, 32'hDEAD_BEEF);
    wr(8'h94, 32'h0BAD_F00D); rd(8'h94, d); check("R3 mask readback", d, 32'h0BAD_F00D);

    // Table walk: R4, R5, R6, R7
    for (int i = 0; i < 8; i++) begin
      logic [31:0] fe, ee, pat;
      {fe, ee, pat} = VEC[i];
      exp = pat & fe & ee;
      wr(8'h48, fe);
      wr(8'h94, ee);
      wr(8'h98, 32'hFFFF_FFFF);
      @(negedge clk); pin_n = ~pat;
      wait_cyc(6);
      rd(8'h80, d); check("R4 masked cause", d, exp);
      check("R7 irq OR", {31'b0, irq}, {31'b0, |exp});
      @(negedge clk); pin_n = '1;
      wait_cyc(6);
      rd(8'h80, d); check("R6 rise keeps cause", d, exp);
      wr(8'h98, 32'hFFFF_FFFF);
      rd(8'h80, d); check("R8 cleared", d, 32'h0);
    end

    // R5: edge with arm off, then enable -> still 0
    wr(8'h48, 32'h0); wr(8'h94, 32'h0);
    @(negedge clk); pin_n[7] = 1'b0;
    wait_cyc(6);
    @(negedge clk); pin_n[7] = 1'b1;
    wait_cyc(4);
    wr(8'h48, 32'hFFFF_FFFF); wr(8'h94, 32'hFFFF_FFFF);
    rd(8'h80, d); check("R5 unarmed edge", d, 32'h0);

    // R7 latency: pin 3
    wr(8'h48, 32'h8); wr(8'h94, 32'h8);
    @(negedge clk); pin_n[3] = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk); check("R7 irq low before 3rd edge", {31'b0, irq}, 32'h0);
    @(posedge clk);
    @(negedge clk); check("R7 irq high at 3rd edge", {31'b0, irq}, 32'h1);

    // R8 hold through second edge and foreign clear
    pin_n[3] = 1'b1;
    wait_cyc(4);
    @(negedge clk); pin_n[3] = 1'b0;
    wait_cyc(6);
    wr(8'h98, 32'h20);
    rd(8'h80, d); check("R8 hold", d, 32'h8);
    check("R8 irq held", {31'b0, irq}, 32'h1);
    rd(8'h98, d); check("R8 clear reads zero", d, 32'h0);
    wr(8'h98, 32'h8);
    @(negedge clk);
    check("R8 irq dropped", {31'b0, irq}, 32'h0);
    rd(8'h80, d); check("R8 cleared bit", d, 32'h0);

    // R9 clear coincident with new edge on pin 3
    @(negedge clk); pin_n[3] = 1'b1;
    wait_cyc(4);
    @(negedge clk); pin_n[3] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 8'h98; bus_wdata = 32'h8; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
    wait_cyc(3);
    rd(8'h80, d); check("R9 clear wins", d, 32'h0);
    check("R9 irq", {31'b0, irq}, 32'h0);
    @(negedge clk); pin_n[3] = 1'b1;

    // R10 unmapped and read-only
    rd(8'h00, d); check("R10 unmapped 0x00", d, 32'h0);
    rd(8'h4C, d); check("R10 unmapped 0x4C", d, 32'h0);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, d); check("R10 write to 0x80 ignored", d, 32'h0);
    check("R10 irq", {31'b0, irq}, 32'h0);

    summary();
  end
endmodule